// File: doc/BRIEF.md
# Four-Byte-Word Multi-Cycle Processor Core

A small multi-cycle processor that runs programs held in a word-addressed memory. It has four 8-bit general registers, a code pointer and a fixed data base. Every instruction fills one 32-bit word. The core fetches a word, splits it into an opcode and two operand bytes, and then executes it.

Three arithmetic-style operations (copy, add, subtract) each come in five operand forms. The destination is a register or a memory word. The source is a register, a memory word or an 8-bit constant. A form with memory on both sides is not allowed. Five jumps, one unconditional and four that test a flag, load the code pointer from operand 1.

A program is started by a pulse on `start_i`. It runs until the core fetches an opcode byte of zero, or until it meets an instruction it cannot decode. The memory port is synchronous: read data appears on the cycle after the address.

Top module: `misc_core`

## Requirements
- R1: After reset the core is idle: `halted_o`=0, `illegal_o`=0, and no memory write happens until `start_i` is pulsed.
- R2: A `start_i` pulse while the core is idle or halted begins execution at word 0. The code pointer advances by one word per fetch. In an instruction word, bits 31:24 are the opcode, bits 23:16 are operand 1, bits 15:8 are operand 2, and bits 7:0 are ignored.
- R3: Opcode 0x1F is a copy, where F is the form. The forms are:
  - F=0: register op1 ← register op2.
  - F=1: memory word op1 ← register op2.
  - F=2: register op1 ← memory word op2.
  - F=3: memory word op1 ← constant op2.
  - F=4: register op1 ← constant op2.

  A memory operand is bits 7:0 of the addressed word. A memory write stores the 8-bit result with bits 31:8 cleared.
- R4: Opcode 0x2F adds the source to the destination, using the same five forms as R3, with 8-bit wrap-around.
- R5: Opcode 0x3F subtracts the source from the destination, using the same five forms, with 8-bit wrap-around.
- R6: Add and subtract update four flags from the 8-bit two's-complement result:
  - positive: result > 0.
  - negative: bit 7 of the result is set.
  - zero: result = 0.
  - overflow: signed overflow.

  A copy leaves every flag unchanged, and at most one of positive, negative and zero is set.
- R7: The jump opcodes load operand 1 into the code pointer: 0x40 always, 0x41 if positive, 0x42 if negative, 0x43 if zero, 0x44 if overflow. A jump whose condition is not met falls through to the next word.
- R8: An opcode byte of 0x00 halts the core. `halted_o` stays 1 and no memory write happens until the next `start_i`.
- R9: Each of the following sets `illegal_o` and halts the core without performing the instruction:
  - an undefined opcode;
  - form 5 (memory ← memory) or a higher form;
  - a register code outside 1..4 in a field the form reads as a register.

  A new start clears `illegal_o`.
- R10: Register codes 1, 2, 3 and 4 select four distinct registers A, B, C and D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin execution at word 0 (honoured when idle or halted) |
| mem_addr_o | output | ADDR_W | Word address for read and write |
| mem_we_o | output | 1 | Write enable for the addressed word |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid one cycle after the address |
| halted_o | output | 1 | Core has stopped |
| illegal_o | output | 1 | Last stop was caused by an undecodable instruction |

## Verification
The assertions assume that the memory returns the word addressed on the previous cycle and never delays it. They also assume that `start_i` matters only while the core is idle or halted. The bench models memory with exactly one cycle of read latency. It pulses `start_i` only after `halted_o` has risen, or from the post-reset idle state. Every program it loads ends in a zero opcode or an illegal word within its 256-word space. Data and code live in separate word ranges, so no program overwrites its own code.

// File: rtl/misc_core_pkg.sv
package misc_core_pkg;
  localparam int BYTE_W    = 8;
  localparam int WORD_W    = 4 * BYTE_W;
  localparam int NUM_REGS  = 4;
  localparam int REG_IDX_W = $clog2(NUM_REGS);

  typedef enum logic [1:0] {ALU_MOV = 2'd0, ALU_ADD = 2'd1, ALU_SUB = 2'd2} alu_op_e;

  // form code is the low nibble of the opcode
  typedef enum logic [2:0] {
    F_RR = 3'd0, F_MR = 3'd1, F_RM = 3'd2, F_MC = 3'd3, F_RC = 3'd4
  } form_e;

  typedef enum logic [1:0] {K_HALT, K_ALU, K_JUMP, K_ILL} kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_LATCH, S_DISPATCH, S_MEMRD, S_EXEC, S_HALT
  } state_e;

  typedef struct packed {
    logic pos;
    logic neg;
    logic zero;
    logic ovf;
  } flags_t;

  typedef struct packed {
    kind_e                kind;
    alu_op_e              op;
    form_e                form;
    logic [REG_IDX_W-1:0] rd;
    logic [REG_IDX_W-1:0] rs;
    logic [2:0]           cond;
  } dec_t;
endpackage

// File: rtl/misc_decoder.sv
module misc_decoder
  import misc_core_pkg::*;
(
  input  logic [BYTE_W-1:0] opc_i,
  input  logic [BYTE_W-1:0] op1_i,
  input  logic [BYTE_W-1:0] op2_i,
  output dec_t              dec_o
);
  function automatic logic reg_ok(input logic [BYTE_W-1:0] code);
    return (code != '0) && (code <= BYTE_W'(NUM_REGS));
  endfunction

  logic form_ok;

  always_comb begin
    dec_o      = '0;
    dec_o.kind = K_ILL;
    dec_o.op   = ALU_MOV;
    dec_o.form = F_RR;
    dec_o.rd   = REG_IDX_W'(op1_i[REG_IDX_W-1:0] - 1'b1);
    dec_o.rs   = REG_IDX_W'(op2_i[REG_IDX_W-1:0] - 1'b1);
    dec_o.cond = opc_i[2:0];
    form_ok    = 1'b0;
    unique case (opc_i[7:4])
      4'h0: dec_o.kind = (opc_i == '0) ? K_HALT : K_ILL;
      4'h1, 4'h2, 4'h3: begin
        dec_o.op = (opc_i[7:4] == 4'h1) ? ALU_MOV :
                   (opc_i[7:4] == 4'h2) ? ALU_ADD : ALU_SUB;
        case (opc_i[3:0])
          4'd0:    form_ok = reg_ok(op1_i) && reg_ok(op2_i);
          4'd1:    form_ok = reg_ok(op2_i);
          4'd2:    form_ok = reg_ok(op1_i);
          4'd3:    form_ok = 1'b1;
          4'd4:    form_ok = reg_ok(op1_i);
          default: form_ok = 1'b0;  // includes memory-to-memory
        endcase
        dec_o.form = form_e'(opc_i[2:0]);
        dec_o.kind = form_ok ? K_ALU : K_ILL;
      end
      4'h4: dec_o.kind = (opc_i[3:0] <= 4'd4) ? K_JUMP : K_ILL;
      default: dec_o.kind = K_ILL;
    endcase
  end
endmodule

// File: rtl/misc_alu.sv
module misc_alu
  import misc_core_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output flags_t       flags_o
);
  always_comb begin
    flags_o.ovf = 1'b0;
    unique case (op_i)
      ALU_ADD: begin
        res_o       = a_i + b_i;
        flags_o.ovf = (a_i[W-1] == b_i[W-1]) && (res_o[W-1] != a_i[W-1]);
      end
      ALU_SUB: begin
        res_o       = a_i - b_i;
        flags_o.ovf = (a_i[W-1] != b_i[W-1]) && (res_o[W-1] != a_i[W-1]);
      end
      default: res_o = b_i;
    endcase
    flags_o.neg  = res_o[W-1];
    flags_o.zero = (res_o == '0);
    flags_o.pos  = !res_o[W-1] && (res_o != '0);
  end
endmodule

// File: rtl/misc_regfile.sv
module misc_regfile
  import misc_core_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [REG_IDX_W-1:0] wa_i,
  input  logic [W-1:0]         wd_i,
  input  logic [REG_IDX_W-1:0] ra_a_i,
  input  logic [REG_IDX_W-1:0] ra_b_i,
  output logic [W-1:0]         rd_a_o,
  output logic [W-1:0]         rd_b_o
);
  logic [NUM_REGS-1:0][W-1:0] regs;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (we_i && wa_i == REG_IDX_W'(g)) q <= wd_i;
    end
    assign regs[g] = q;
  end

  assign rd_a_o = regs[ra_a_i];
  assign rd_b_o = regs[ra_b_i];
endmodule

// File: rtl/misc_core.sv
module misc_core
  import misc_core_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_BASE = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  output logic              halted_o,
  output logic              illegal_o
);
  localparam int IR_W = WORD_W - BYTE_W;  // low byte of a code word is never kept

  state_e              state_q, state_d;
  logic [ADDR_W-1:0]   pc_q;
  logic [IR_W-1:0]     ir_q;
  flags_t              flags_q;
  logic                illegal_q;

  logic [BYTE_W-1:0]   opc, op1, op2;
  dec_t                dec;
  logic [BYTE_W-1:0]   rf_a, rf_b, alu_a, alu_b, alu_res;
  flags_t              alu_flg;
  logic                dest_mem, needs_read, do_exec, jump_taken, start_ok;
  logic [ADDR_W-1:0]   data_addr;

  assign opc = ir_q[IR_W-1 -: BYTE_W];
  assign op1 = ir_q[IR_W-BYTE_W-1 -: BYTE_W];
  assign op2 = ir_q[BYTE_W-1:0];

  misc_decoder u_dec (.opc_i(opc), .op1_i(op1), .op2_i(op2), .dec_o(dec));

  misc_regfile #(.W(BYTE_W)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (do_exec && !dest_mem),
    .wa_i   (dec.rd),
    .wd_i   (alu_res),
    .ra_a_i (dec.rd),
    .ra_b_i (dec.rs),
    .rd_a_o (rf_a),
    .rd_b_o (rf_b)
  );

  misc_alu #(.W(BYTE_W)) u_alu (
    .op_i    (dec.op),
    .a_i     (alu_a),
    .b_i     (alu_b),
    .res_o   (alu_res),
    .flags_o (alu_flg)
  );

  always_comb begin
    dest_mem   = dec.form inside {F_MR, F_MC};
    needs_read = (dec.form == F_RM) || (dest_mem && dec.op != ALU_MOV);
    data_addr  = ADDR_W'(DATA_BASE) + ADDR_W'(dest_mem ? op1 : op2);
    do_exec    = (dec.kind == K_ALU) &&
                 ((state_q == S_DISPATCH && !needs_read) || state_q == S_EXEC);
    start_ok   = start_i && (state_q == S_IDLE || state_q == S_HALT);
    alu_a      = dest_mem ? mem_rdata_i[BYTE_W-1:0] : rf_a;
    case (dec.form)
      F_RR, F_MR: alu_b = rf_b;
      F_RM:       alu_b = mem_rdata_i[BYTE_W-1:0];
      default:    alu_b = op2;
    endcase
    case (dec.cond)
      3'd0:    jump_taken = 1'b1;
      3'd1:    jump_taken = flags_q.pos;
      3'd2:    jump_taken = flags_q.neg;
      3'd3:    jump_taken = flags_q.zero;
      3'd4:    jump_taken = flags_q.ovf;
      default: jump_taken = 1'b0;
    endcase
  end

  assign mem_we_o    = do_exec && dest_mem;
  assign mem_addr_o  = (state_q == S_MEMRD || mem_we_o) ? data_addr : pc_q;
  assign mem_wdata_o = {{(WORD_W-BYTE_W){1'b0}}, alu_res};
  assign halted_o    = (state_q == S_HALT);
  assign illegal_o   = illegal_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE, S_HALT: if (start_i) state_d = S_FETCH;
      S_FETCH:        state_d = S_LATCH;
      S_LATCH:        state_d = S_DISPATCH;
      S_DISPATCH: begin
        unique case (dec.kind)
          K_ALU:   state_d = needs_read ? S_MEMRD : S_FETCH;
          K_JUMP:  state_d = S_FETCH;
          default: state_d = S_HALT;
        endcase
      end
      S_MEMRD:        state_d = S_EXEC;
      S_EXEC:         state_d = S_FETCH;
      default:        state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      pc_q      <= '0;
      ir_q      <= '0;
      flags_q   <= '0;
      illegal_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_ok) begin
        pc_q      <= '0;
        illegal_q <= 1'b0;
      end
      if (state_q == S_LATCH) begin
        ir_q <= mem_rdata_i[WORD_W-1:BYTE_W];
        pc_q <= pc_q + ADDR_W'(1);
      end
      if (state_q == S_DISPATCH) begin
        if (dec.kind == K_ILL) illegal_q <= 1'b1;
        if (dec.kind == K_JUMP && jump_taken) pc_q <= ADDR_W'(op1);
      end
      if (do_exec && dec.op != ALU_MOV) flags_q <= alu_flg;
    end
  end

  AST_HALT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o && !start_i |=> halted_o);  // R8
  AST_NO_WRITE_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_HALT || state_q == S_IDLE) |-> !mem_we_o);  // R8
  AST_ILLEGAL_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> halted_o);  // R9
  AST_START_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o && start_i |=> (mem_addr_o == '0 && !illegal_o));  // R2
  AST_MOVE_KEEPS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_exec && dec.op == ALU_MOV |=> $stable(flags_q));  // R6
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({flags_q.pos, flags_q.neg, flags_q.zero}));  // R6
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DISPATCH && dec.kind == K_ILL) |-> !mem_we_o);  // R9
endmodule

// File: tb/misc_core_tb.sv
`timescale 1ns/1ps
module misc_core_tb;
  localparam int ADDR_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WD_MAX = 100000;

  // {op nibble, a, b, expected result, expected flags {pos,neg,zero,ovf}}
  localparam logic [31:0] VEC [8] = '{
    32'h2_03_04_07_8, 32'h2_7F_01_80_5, 32'h2_FF_01_00_2, 32'h3_05_05_00_2,
    32'h3_03_05_FE_4, 32'h3_80_01_7F_9, 32'h2_80_80_00_3, 32'h3_7F_FF_80_5
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_we;
  logic [31:0]       mem_wdata;
  logic [31:0]       rdata;
  logic              halted, illegal;
  logic [31:0]       mem [DEPTH];
  int                wr_cnt = 0;
  int                checks = 0;
  int                errors = 0;

  always #2 clk = ~clk;

  misc_core #(.ADDR_W(ADDR_W), .DATA_BASE(0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(rdata), .halted_o(halted), .illegal_o(illegal)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    rdata <= mem[mem_addr];
  end

  function automatic logic [31:0] ins(input logic [7:0] opc, input logic [7:0] o1,
                                      input logic [7:0] o2);
    return {opc, o1, o2, 8'h00};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < DEPTH; i++) mem[i] = 32'h0;
  endtask

  task automatic run_prog();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 0; i < 3000 && !halted; i++) @(negedge clk);
  endtask

  initial begin
    repeat (WD_MAX) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state and idle with no writes
    chk("R1", "halted after reset", 32'(halted), 32'd0);
    chk("R1", "illegal after reset", 32'(illegal), 32'd0);
    repeat (10) @(negedge clk);
    chk("R1", "writes while idle", 32'(wr_cnt), 32'd0);

    // R4 R5 R6: table of add/sub vectors, flags captured through conditional jumps
    for (int v = 0; v < 8; v++) begin
      logic [3:0] op;
      logic [7:0] a, b, r;
      logic [3:0] fl;
      op = VEC[v][31:28]; a = VEC[v][27:20]; b = VEC[v][19:12];
      r = VEC[v][11:4]; fl = VEC[v][3:0];
      clear_mem();
      mem[0] = ins(8'h14, 8'd1, a);
      mem[1] = ins(8'h14, 8'd2, b);
      mem[2] = ins({op, 4'h0}, 8'd1, 8'd2);
      mem[3] = ins(8'h11, 8'h80, 8'd1);
      for (int k = 0; k < 4; k++) begin
        int w;
        w = 4 + 3 * k;
        mem[w]     = ins(8'(8'h41 + k), 8'(w + 2), 8'h00);
        mem[w + 1] = ins(8'h40, 8'(w + 3), 8'h00);
        mem[w + 2] = ins(8'h13, 8'(8'h81 + k), 8'h01);
      end
      run_prog();
      chk(op == 4'h2 ? "R4" : "R5", "result word", mem[8'h80], {24'h0, r});
      chk("R6", "flags pos/neg/zero/ovf",
          {28'h0, mem[8'h81][0], mem[8'h82][0], mem[8'h83][0], mem[8'h84][0]}, {28'h0, fl});
    end

    // R3 R4 R5: every operand form
    clear_mem();
    mem[8'h60] = 32'hAABBCC11;
    mem[0]  = ins(8'h12, 8'd4, 8'h60);
    mem[1]  = ins(8'h11, 8'h61, 8'd4);
    mem[2]  = ins(8'h10, 8'd3, 8'd4);
    mem[3]  = ins(8'h21, 8'h61, 8'd3);
    mem[4]  = ins(8'h23, 8'h61, 8'h05);
    mem[5]  = ins(8'h14, 8'd1, 8'h30);
    mem[6]  = ins(8'h32, 8'd1, 8'h61);
    mem[7]  = ins(8'h24, 8'd1, 8'h01);
    mem[8]  = ins(8'h33, 8'h61, 8'h07);
    mem[9]  = ins(8'h31, 8'h61, 8'd1);
    mem[10] = ins(8'h11, 8'h62, 8'd1);
    mem[11] = ins(8'h22, 8'd3, 8'h62);
    mem[12] = ins(8'h30, 8'd3, 8'd1);
    mem[13] = ins(8'h20, 8'd3, 8'd3);
    mem[14] = ins(8'h11, 8'h63, 8'd3);
    mem[15] = ins(8'h13, 8'h64, 8'h99);
    run_prog();
    chk("R3", "source word untouched", mem[8'h60], 32'hAABBCC11);
    chk("R5", "mem forms chain", mem[8'h61], 32'h16);
    chk("R4", "reg from const/mem", mem[8'h62], 32'h0A);
    chk("R4", "reg-reg add", mem[8'h63], 32'h22);
    chk("R3", "mem from const", mem[8'h64], 32'h99);

    // R10 four distinct registers
    clear_mem();
    for (int i = 0; i < 4; i++) begin
      mem[i]     = ins(8'h14, 8'(i + 1), 8'(8'hA0 + i));
      mem[i + 4] = ins(8'h11, 8'(8'h78 + i), 8'(i + 1));
    end
    run_prog();
    for (int i = 0; i < 4; i++)
      chk("R10", "register store", mem[8'h78 + i], 32'(8'hA0 + i));

    // R2 field positions; low byte ignored
    clear_mem();
    mem[0] = {8'h13, 8'h90, 8'h5A, 8'hEE};
    run_prog();
    chk("R2", "fields decoded", mem[8'h90], 32'h5A);

    // R7 unconditional jump
    clear_mem();
    mem[0] = ins(8'h40, 8'd2, 8'h00);
    mem[1] = ins(8'h13, 8'h70, 8'h01);
    mem[2] = ins(8'h13, 8'h71, 8'h02);
    run_prog();
    chk("R7", "skipped word", mem[8'h70], 32'h0);
    chk("R7", "target word", mem[8'h71], 32'h2);

    // R8 stays halted, no writes, restart from word 0
    begin
      int w0;
      w0 = wr_cnt;
      repeat (20) @(negedge clk);
      chk("R8", "still halted", 32'(halted), 32'd1);
      chk("R8", "no writes while halted", 32'(wr_cnt), 32'(w0));
      mem[8'h71] = 32'h0;
      run_prog();
      chk("R8", "restart reruns", mem[8'h71], 32'h2);
    end

    // R9 memory-to-memory form
    clear_mem();
    mem[0] = ins(8'h13, 8'h72, 8'h05);
    mem[1] = ins(8'h15, 8'h72, 8'h73);
    mem[2] = ins(8'h13, 8'h73, 8'h09);
    run_prog();
    chk("R9", "illegal mem-mem", 32'(illegal), 32'd1);
    chk("R9", "halted on illegal", 32'(halted), 32'd1);
    chk("R9", "before illegal", mem[8'h72], 32'h5);
    chk("R9", "after illegal", mem[8'h73], 32'h0);

    // R9 undefined opcode, bad register codes, clear on restart
    clear_mem();
    mem[0] = ins(8'h50, 8'h00, 8'h00);
    run_prog();
    chk("R9", "undefined opcode", 32'(illegal), 32'd1);
    clear_mem();
    mem[0] = ins(8'h14, 8'h00, 8'h05);
    run_prog();
    chk("R9", "register code 0", 32'(illegal), 32'd1);
    clear_mem();
    mem[0] = ins(8'h10, 8'd1, 8'd5);
    run_prog();
    chk("R9", "register code 5", 32'(illegal), 32'd1);
    clear_mem();
    mem[0] = ins(8'h13, 8'h74, 8'h01);
    run_prog();
    chk("R9", "cleared by start", 32'(illegal), 32'd0);
    chk("R8", "zero opcode halts", 32'(halted), 32'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule